// File: doc/BRIEF.md
# IR Carrier Envelope Demodulator

This block turns a carrier-modulated infrared receiver signal back into its mark/space envelope. A programmable divider splits the reference clock into receive ticks, each lasting (divider + 1) reference clocks. A carrier cycle is nominally 16 ticks long. The block measures the gap between successive rising carrier edges and accepts a gap only when it falls inside a selectable early/late tolerance. Two accepted gaps in a row declare a mark. A missing edge past the late limit, or an edge outside the window, returns the output to space.

Ahead of the demodulator, the raw pin passes through a two-flop synchronizer and a minimum-width glitch filter counted in reference clocks. When demodulation is switched off, the filtered level goes straight to the output, with high meaning mark. The receive enable gates the output and clears all timing state. Pulse-width measurement, buffering and the register interface belong to neighbouring blocks.

Top module: `ir_carrier_demod`

## Requirements
- R1: While reset is asserted, `mark_o` is 0 whatever the inputs are.
- R2: One receive tick lasts `rx_div + 1` reference clocks. A carrier whose rising edges are exactly 16 ticks apart gives a mark for any divider value.
- R3: The window code sets the accepted gap between rising edges. Bit 0 sets the early limit: 0 accepts gaps down to 13 ticks, 1 down to 12. Bit 1 sets the late limit: 0 accepts gaps up to 19 ticks, 1 up to 20. Gaps outside the window never produce a mark.
- R4: A mark is declared only on the rising edge that closes the second consecutive in-window gap. An out-of-window edge returns the output to space at once and restarts the count.
- R5: Once more ticks than the late limit have passed without a rising edge, the output returns to space.
- R6: With `demod_en` low, `mark_o` follows the filtered input level, with 1 meaning mark.
- R7: With `lpf_count` of 4 or more, a pulse of the synchronized input shorter than `lpf_count` reference clocks is removed. A pulse at least that long passes with its width kept.
- R8: `lpf_count` values 0 to 3 disable the filter, so even a single-clock pulse passes.
- R9: With `rx_en` low, `mark_o` is 0 and the tick and window state are cleared. After `rx_en` is raised again, a new mark needs fresh in-window gaps.
- R10: In bypass with the filter disabled, a change on `ir_in` shows on `mark_o` after exactly three rising clock edges: two synchronizer stages and the filter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw infrared receiver pin, asynchronous |
| rx_en | input | 1 | Receive enable; low forces space and clears state |
| demod_en | input | 1 | 1 selects the carrier demodulator, 0 passes the filtered level |
| rx_div | input | DIV_W (16) | Tick divider; tick = rx_div + 1 reference clocks |
| win_code | input | 2 | Window select: bit 0 widens the early side, bit 1 the late side |
| lpf_count | input | LPF_W (16) | Minimum accepted pulse width in reference clocks; below 4 disables |
| mark_o | output | 1 | Demodulated level, 1 = mark |

## Verification
On a single rising carrier edge, the window tracker can both restart its tick count and have a divider tick land in the same clock. If that tick is lost, the measured gap comes out one short, depending on the phase. The bench provokes this by running carriers at exact multiples of the tick length, for example 16, 13 and 20 ticks with a divider of 1 and 3, so edges align with ticks at a fixed phase. It judges the result by checking that the boundary gaps 12/13 and 19/20/21 are accepted or rejected exactly as the window code dictates. A second same-cycle case is an in-window edge arriving just as the timeout limit is reached. The 20-tick gap under a +4 window must keep the mark steady through the later periods.

// File: rtl/ir_demod_pkg.sv
package ir_demod_pkg;
    localparam int unsigned NOM_TICKS = 16;
    localparam int unsigned WIN_MAX   = 4;
    localparam int unsigned FILT_MIN  = 4;
    localparam int unsigned CNT_SAT   = NOM_TICKS + WIN_MAX + 1;
    localparam int unsigned TCNT_W    = $clog2(CNT_SAT + 1);

    typedef logic [TCNT_W-1:0] tcnt_t;

    typedef struct packed {
        tcnt_t lo;
        tcnt_t hi;
    } win_lim_t;

    // bit 0 widens the early side, bit 1 widens the late side
    function automatic win_lim_t win_limits(input logic [1:0] code);
        win_lim_t w;
        w.lo = tcnt_t'(NOM_TICKS - (code[0] ? 32'd4 : 32'd3));
        w.hi = tcnt_t'(NOM_TICKS + (code[1] ? 32'd4 : 32'd3));
        return w;
    endfunction
endpackage

// File: rtl/ir_sync.sv
module ir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ir_glitch_filter.sv
module ir_glitch_filter
    import ir_demod_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          x,
    input  logic [CW-1:0] min_w,
    output logic          y
);
    typedef struct packed {
        logic          y;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [CW:0] run_len;

    always_comb begin
        s_d     = s_q;
        run_len = {1'b0, s_q.cnt} + (CW+1)'(1);
        if (clr) begin
            s_d = '0;
        end else if (min_w < CW'(FILT_MIN)) begin
            s_d.y   = x;
            s_d.cnt = '0;
        end else if (x == s_q.y) begin
            s_d.cnt = '0;
        end else if (run_len >= {1'b0, min_w}) begin
            s_d.y   = x;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = run_len[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign y = s_q.y;
endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    assign tick = en && (s_q.cnt >= div);

    always_comb begin
        s_d = s_q;
        if (!en || tick) s_d.cnt = '0;
        else             s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ir_carrier_window.sv
module ir_carrier_window
    import ir_demod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic       lvl,
    input  logic [1:0] win_code,
    output logic       cedge,
    output tcnt_t      tick_cnt,
    output logic       mark
);
    typedef struct packed {
        logic       prev;
        tcnt_t      cnt;
        logic [1:0] streak;
        logic       mark;
    } st_t;

    st_t      s_d, s_q;
    win_lim_t lim;
    logic     in_win;

    assign cedge  = lvl & ~s_q.prev;
    assign lim    = win_limits(win_code);
    assign in_win = (s_q.cnt >= lim.lo) && (s_q.cnt <= lim.hi);

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl;
        if (clr) begin
            s_d = '0;
        end else if (cedge) begin
            // count ticks in [edge, next edge): a tick in the edge cycle is the first
            s_d.cnt = tick ? tcnt_t'(1) : '0;
            if (in_win) begin
                if (s_q.streak != 2'd2) s_d.streak = s_q.streak + 2'd1;
                s_d.mark = (s_q.streak != 2'd0);
            end else begin
                s_d.streak = '0;
                s_d.mark   = 1'b0;
            end
        end else begin
            if (tick && (s_q.cnt != tcnt_t'(CNT_SAT))) s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt > lim.hi) begin
                s_d.streak = '0;
                s_d.mark   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_cnt = s_q.cnt;
    assign mark     = s_q.mark;
endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod
    import ir_demod_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int LPF_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_in,
    input  logic             rx_en,
    input  logic             demod_en,
    input  logic [DIV_W-1:0] rx_div,
    input  logic [1:0]       win_code,
    input  logic [LPF_W-1:0] lpf_count,
    output logic             mark_o
);
    logic  sync_lvl;
    logic  filt_lvl;
    logic  tick;
    logic  cedge;
    tcnt_t tick_cnt;
    logic  carrier_mark;

    ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_in),
        .q     (sync_lvl)
    );

    ir_glitch_filter #(.CW(LPF_W)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rx_en),
        .x     (sync_lvl),
        .min_w (lpf_count),
        .y     (filt_lvl)
    );

    ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rx_en),
        .div   (rx_div),
        .tick  (tick)
    );

    ir_carrier_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_en),
        .tick     (tick),
        .lvl      (filt_lvl),
        .win_code (win_code),
        .cedge    (cedge),
        .tick_cnt (tick_cnt),
        .mark     (carrier_mark)
    );

    assign mark_o = rx_en && (demod_en ? carrier_mark : filt_lvl);
endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk
    import ir_demod_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LPF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic [DIV_W-1:0] rx_div,
    input logic [1:0]       win_code,
    input logic [LPF_W-1:0] lpf_count,
    input logic             sync_lvl,
    input logic             filt_lvl,
    input logic             tick,
    input logic             cedge,
    input tcnt_t            tick_cnt,
    input logic             carrier_mark
);
    win_lim_t         lim;
    logic [DIV_W:0]   gap_q;
    logic [DIV_W-1:0] div_q;
    logic             valid_q;

    assign lim = win_limits(win_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            div_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            div_q <= rx_div;
            if (tick) gap_q <= '0;
            else if (gap_q != {(DIV_W+1){1'b1}}) gap_q <= gap_q + 1'b1;
            if (!rx_en || (rx_div != div_q)) valid_q <= 1'b0;
            else if (tick) valid_q <= 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && valid_q && (rx_div == div_q) |-> gap_q == {1'b0, rx_div}); // R2

    AST_MARK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_mark) |-> $past(cedge)); // R4

    AST_MARK_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_mark && !cedge && (tick_cnt > lim.hi) |=> !carrier_mark); // R5

    AST_FILT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && $changed(filt_lvl) |-> filt_lvl == $past(sync_lvl)); // R7

    AST_FILT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && (lpf_count < LPF_W'(FILT_MIN)) |=> filt_lvl == $past(sync_lvl)); // R8

    AST_RX_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_en) |-> !carrier_mark && (tick_cnt == '0) && !filt_lvl); // R9
endmodule

bind ir_carrier_demod ir_carrier_demod_chk #(.DIV_W(DIV_W), .LPF_W(LPF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .rx_div       (rx_div),
    .win_code     (win_code),
    .lpf_count    (lpf_count),
    .sync_lvl     (sync_lvl),
    .filt_lvl     (filt_lvl),
    .tick         (tick),
    .cedge        (cedge),
    .tick_cnt     (tick_cnt),
    .carrier_mark (carrier_mark)
);

// File: tb/ir_carrier_demod_tb.sv
`timescale 1ns/1ps
module ir_carrier_demod_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ir_in;
    logic        rx_en;
    logic        demod_en;
    logic [15:0] rx_div;
    logic [1:0]  win_code;
    logic [15:0] lpf_count;
    logic        mark_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ir_carrier_demod u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_in     (ir_in),
        .rx_en     (rx_en),
        .demod_en  (demod_en),
        .rx_div    (rx_div),
        .win_code  (win_code),
        .lpf_count (lpf_count),
        .mark_o    (mark_o)
    );

    // {div[3:0], win[1:0], gap ticks[5:0], expect mark}
    localparam logic [12:0] VEC [16] = '{
        {4'd1, 2'd0, 6'd16, 1'b1},
        {4'd1, 2'd0, 6'd13, 1'b1},
        {4'd1, 2'd0, 6'd12, 1'b0},
        {4'd1, 2'd0, 6'd19, 1'b1},
        {4'd1, 2'd0, 6'd20, 1'b0},
        {4'd1, 2'd1, 6'd12, 1'b1},
        {4'd1, 2'd1, 6'd20, 1'b0},
        {4'd1, 2'd2, 6'd20, 1'b1},
        {4'd1, 2'd2, 6'd12, 1'b0},
        {4'd1, 2'd3, 6'd12, 1'b1},
        {4'd1, 2'd3, 6'd20, 1'b1},
        {4'd1, 2'd3, 6'd21, 1'b0},
        {4'd1, 2'd3, 6'd11, 1'b0},
        {4'd0, 2'd0, 6'd16, 1'b1},
        {4'd3, 2'd0, 6'd18, 1'b1},
        {4'd3, 2'd2, 6'd21, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive n carrier periods of p clocks; count mark samples from cycle index skip on
    task automatic run_periods(input int p, input int n, input int skip,
                               output int highs, output int samples);
        int idx = 0;
        highs   = 0;
        samples = 0;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < p; c++) begin
                ir_in = (c < p / 2);
                @(negedge clk);
                if (idx >= skip) begin
                    samples++;
                    if (mark_o) highs++;
                end
                idx++;
            end
        end
    endtask

    task automatic pulse(input int w, input int tail, output int highs);
        highs = 0;
        ir_in = 1'b1;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (mark_o) highs++;
        end
        ir_in = 1'b0;
        for (int i = 0; i < tail; i++) begin
            @(negedge clk);
            if (mark_o) highs++;
        end
    endtask

    task automatic restart(input int div, input int win, input int lpf, input bit dm);
        rx_en = 1'b0;
        ir_in = 1'b0;
        rx_div    = 16'(div);
        win_code  = 2'(win);
        lpf_count = 16'(lpf);
        demod_en  = dm;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, s;
        rst_n = 1'b0; ir_in = 1'b1; rx_en = 1'b1; demod_en = 1'b0;
        rx_div = 16'd1; win_code = 2'd0; lpf_count = 16'd0;
        repeat (4) @(negedge clk);
        chk(mark_o == 1'b0, "R1 reset forces space", int'(mark_o), 0);
        ir_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10/R6: bypass latency of three edges
        ir_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(mark_o == 1'b0, "R10 not yet after two edges", int'(mark_o), 0);
        @(negedge clk);
        chk(mark_o == 1'b1, "R10 R6 bypass high after three edges", int'(mark_o), 1);
        ir_in = 1'b0;
        repeat (5) @(negedge clk);
        chk(mark_o == 1'b0, "R6 bypass follows low", int'(mark_o), 0);

        // R7 filter boundary
        restart(1, 0, 10, 1'b0);
        pulse(9, 30, h);
        chk(h == 0, "R7 pulse of 9 with count 10 removed", h, 0);
        pulse(10, 30, h);
        chk(h == 10, "R7 pulse of 10 passes with width kept", h, 10);
        // R8 small counts disable the filter
        restart(1, 0, 3, 1'b0);
        pulse(1, 10, h);
        chk(h == 1, "R8 count 3 passes one-clock pulse", h, 1);
        restart(1, 0, 0, 1'b0);
        pulse(1, 10, h);
        chk(h == 1, "R8 count 0 passes one-clock pulse", h, 1);

        // vector table: R2 R3
        for (int i = 0; i < 16; i++) begin
            int div, win, n, p;
            bit exp;
            div = int'(VEC[i][12:9]);
            win = int'(VEC[i][8:7]);
            n   = int'(VEC[i][6:1]);
            exp = VEC[i][0];
            p   = n * (div + 1);
            restart(div, win, 0, 1'b1);
            run_periods(p, 8, 5 * p, h, s);
            if (exp) chk(h == s, $sformatf("R2 R3 vec%0d gap %0d win %0d div %0d", i, n, win, div), h, s);
            else     chk(h == 0, $sformatf("R3 vec%0d gap %0d win %0d div %0d", i, n, win, div), h, 0);
        end

        // R4: an out-of-window edge breaks the mark; two good gaps restore it
        restart(1, 0, 0, 1'b1);
        run_periods(32, 6, 0, h, s);
        chk(mark_o == 1'b1, "R4 mark established", int'(mark_o), 1);
        run_periods(24, 1, 0, h, s);
        run_periods(32, 1, 6, h, s);
        chk(h == 0, "R4 out-of-window edge drops mark", h, 0);
        run_periods(32, 1, 6, h, s);
        chk(h == 0, "R4 one good gap not enough", h, 0);
        run_periods(32, 1, 6, h, s);
        chk(h == s, "R4 second good gap restores mark", h, s);

        // R5: timeout after the late limit
        run_periods(32, 2, 0, h, s);
        ir_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(mark_o == 1'b1, "R5 mark held just after carrier stops", int'(mark_o), 1);
        repeat (30) @(negedge clk);
        chk(mark_o == 1'b0, "R5 space after late limit passes", int'(mark_o), 0);

        // R9: receive enable gates and clears
        restart(1, 3, 0, 1'b1);
        run_periods(32, 5, 0, h, s);
        chk(mark_o == 1'b1, "R9 mark before disable", int'(mark_o), 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk(mark_o == 1'b0, "R9 space while disabled", int'(mark_o), 0);
        run_periods(32, 1, 0, h, s);
        rx_en = 1'b1;
        run_periods(32, 1, 0, h, s);
        chk(h == 0, "R9 no mark in first period after re-enable", h, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule